// File: doc/BRIEF.md
# Register Write Lock Guard

This block sits between a 32-bit register bus and a small peripheral register file and decides, for each write, whether the file may take it. It has two registers of its own: a lock status word at byte address 0x000 and a write-only key staging word at byte address 0x07C. While the guard is open, ordinary writes go through to the register file. A write of any value to either of the two lock addresses shuts it. While it is shut, every ordinary write is dropped and reported on a one-cycle error pulse.

Reopening takes two writes in a fixed order. The first key word is written into the staging register. The second key word is then written to the status register. Only that exact pair reopens the guard. A wrong second word, or a wrong staged word, is dropped without an error pulse. Reads of the two lock addresses are answered by the guard, one cycle after the read strobe. A claim flag tells the surrounding read mux that the data came from here.

Top module: `reg_write_lock`

## Requirements
- R1: After reset the guard is open: `lockedOut` is 0, `wrError` is 0, and a read of the status address (0x000) returns 0.
- R2: While open, a write of any data to address 0x000 or 0x07C shuts the guard at that clock edge and clears the staging register to 0. The write is not passed on: `wrPermit` stays 0, and a following status read returns 1.
- R3: While shut, a write to any address other than 0x000 and 0x07C keeps `wrPermit` at 0 in its own cycle and raises `wrError` for exactly the next cycle.
- R4: While open, a write to any address other than the two lock addresses drives `wrPermit` to 1 combinationally in the same cycle, and `wrError` stays 0.
- R5: While shut, a write to 0x07C replaces the staging value with the written word; the last staged word is the one that counts. It raises no error and no permit.
- R6: While shut, a write of 0xC0DEFA73 to 0x000 when the staging register holds 0xC0DE1248 opens the guard at that edge and clears the staging register, so the next lock/unlock cycle needs a fresh staging write. No other write ever opens the guard.
- R7: While shut, a write to 0x000 whose data is not 0xC0DEFA73, or whose staged word is not 0xC0DE1248 (including the two keys swapped), leaves the guard shut and raises no error.
- R8: Reads are registered. In the cycle after `busRe`, a read of 0x000 returns the lock bit in bit 0 with all other bits 0. A read of 0x07C returns 0. `rdOwn` is 1 for those two addresses. Any other address, or no read, gives `busRdata` 0 and `rdOwn` 0.
- R9: Rejected writes on consecutive cycles give an error pulse in each following cycle, and `wrError` returns to 0 after a write that is not rejected.
- R10: While open, a write of the staging key 0xC0DE1248 to 0x07C only arms the lock. The staged word is cleared, so an immediate status write of 0xC0DEFA73 does not reopen the guard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access, word aligned |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one access per cycle |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Read data for the lock addresses, one cycle after `busRe` |
| rdOwn | output | 1 | The guard answered the previous cycle's read |
| wrPermit | output | 1 | Combinational: the register file may take this write |
| wrError | output | 1 | One-cycle pulse after each rejected write |
| lockedOut | output | 1 | Current lock state |

## Verification
The hardest state to reach is a shut guard whose staging register holds the correct key while the status register is hit with words that differ from the unlock key by a single bit. Only this state shows that every bit of both keys takes part in the comparison. The stimulus arms the lock, stages the right key, and sweeps a one-bit flip across all 32 positions of the status word. It then reverses the roles, staging one-bit variants of the staging key before a correct status word. A second hard case is the staging register being cleared by arming and by unlocking. This is reached by arming through a staging write that carries the key itself, then attempting an immediate unlock.

// File: rtl/wl_lock_pkg.sv
package wl_lock_pkg;

  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_SHUT = 1'b1
  } lockStateT;

  // Strobes from the control to the datapath for one accepted write
  typedef struct packed {
    logic armGo;       // open guard shuts
    logic unlockGo;    // key pair matched, guard opens
    logic stageLoad;   // staging register takes write data
    logic stageClear;  // staging register returns to zero
    logic reject;      // ordinary write dropped while shut
  } lockCmdT;

endpackage

// File: rtl/wl_decode.sv
module wl_decode #(
  parameter int          ADDR_W     = 12,
  parameter int          STATUS_OFS = 'h000,
  parameter int          STAGE_OFS  = 'h07C,
  parameter logic [31:0] KEY_UNLOCK = 32'hC0DEFA73
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              hitStatus,
  output logic              hitStage,
  output logic              unlockKeyOk
);

  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] StageAddr  = ADDR_W'(STAGE_OFS);

  always_comb begin
    hitStatus   = (busAddr == StatusAddr);
    hitStage    = (busAddr == StageAddr);
    unlockKeyOk = (busWdata == KEY_UNLOCK);
  end

endmodule

// File: rtl/wl_ctrl.sv
module wl_ctrl
  import wl_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busWe,
  input  logic      hitStatus,
  input  logic      hitStage,
  input  logic      unlockKeyOk,
  input  logic      stageKeyOk,
  output lockCmdT   cmd,
  output lockStateT lockState,
  output logic      wrPermit,
  output logic      wrError
);

  lockStateT stateQ, stateD;
  logic      lockHit;

  assign lockHit = hitStatus | hitStage;

  always_comb begin
    cmd = '0;
    if (busWe) begin
      if (stateQ == LK_OPEN) begin
        if (lockHit) begin
          cmd.armGo      = 1'b1;
          cmd.stageClear = 1'b1;
        end
      end else begin
        if (hitStage) begin
          cmd.stageLoad = 1'b1;
        end else if (hitStatus) begin
          if (unlockKeyOk && stageKeyOk) begin
            cmd.unlockGo   = 1'b1;
            cmd.stageClear = 1'b1;
          end
        end else begin
          cmd.reject = 1'b1;
        end
      end
    end
  end

  always_comb begin
    stateD = stateQ;
    if (cmd.armGo)    stateD = LK_SHUT;
    if (cmd.unlockGo) stateD = LK_OPEN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= LK_OPEN;
      wrError <= 1'b0;
    end else begin
      stateQ  <= stateD;
      wrError <= cmd.reject;
    end
  end

  assign wrPermit  = busWe && (stateQ == LK_OPEN) && !lockHit;
  assign lockState = stateQ;

endmodule

// File: rtl/wl_datapath.sv
module wl_datapath
  import wl_lock_pkg::*;
#(
  parameter logic [31:0] KEY_STAGE = 32'hC0DE1248
) (
  input  logic        clk,
  input  logic        rstN,
  input  lockCmdT     cmd,
  input  logic [31:0] busWdata,
  input  logic        busRe,
  input  logic        hitStatus,
  input  logic        hitStage,
  input  lockStateT   lockState,
  output logic        stageKeyOk,
  output logic [31:0] busRdata,
  output logic        rdOwn
);

  logic [31:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else if (cmd.stageClear) begin
      stageQ <= '0;
    end else if (cmd.stageLoad) begin
      stageQ <= busWdata;
    end
  end

  assign stageKeyOk = (stageQ == KEY_STAGE);

  // Read answer is registered; the staging word never leaves the block
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      rdOwn    <= 1'b0;
    end else begin
      rdOwn    <= busRe && (hitStatus || hitStage);
      busRdata <= (busRe && hitStatus) ? {31'b0, lockState == LK_SHUT} : 32'b0;
    end
  end

endmodule

// File: rtl/reg_write_lock.sv
module reg_write_lock
  import wl_lock_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          STATUS_OFS = 'h000,
  parameter int          STAGE_OFS  = 'h07C,
  parameter logic [31:0] KEY_STAGE  = 32'hC0DE1248,
  parameter logic [31:0] KEY_UNLOCK = 32'hC0DEFA73
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [31:0]       busRdata,
  output logic              rdOwn,
  output logic              wrPermit,
  output logic              wrError,
  output logic              lockedOut
);

  logic      hitStatus, hitStage, unlockKeyOk, stageKeyOk;
  lockCmdT   cmd;
  lockStateT lockState;

  wl_decode #(
    .ADDR_W    (ADDR_W),
    .STATUS_OFS(STATUS_OFS),
    .STAGE_OFS (STAGE_OFS),
    .KEY_UNLOCK(KEY_UNLOCK)
  ) u_decode (
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .hitStatus  (hitStatus),
    .hitStage   (hitStage),
    .unlockKeyOk(unlockKeyOk)
  );

  wl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWe      (busWe),
    .hitStatus  (hitStatus),
    .hitStage   (hitStage),
    .unlockKeyOk(unlockKeyOk),
    .stageKeyOk (stageKeyOk),
    .cmd        (cmd),
    .lockState  (lockState),
    .wrPermit   (wrPermit),
    .wrError    (wrError)
  );

  wl_datapath #(
    .KEY_STAGE(KEY_STAGE)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .busWdata  (busWdata),
    .busRe     (busRe),
    .hitStatus (hitStatus),
    .hitStage  (hitStage),
    .lockState (lockState),
    .stageKeyOk(stageKeyOk),
    .busRdata  (busRdata),
    .rdOwn     (rdOwn)
  );

  assign lockedOut = (lockState == LK_SHUT);

endmodule

// File: rtl/wl_lock_checker.sv
module wl_lock_checker #(
  parameter int          ADDR_W     = 12,
  parameter int          STATUS_OFS = 'h000,
  parameter int          STAGE_OFS  = 'h07C,
  parameter logic [31:0] KEY_UNLOCK = 32'hC0DEFA73
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busWe,
  input logic              busRe,
  input logic [31:0]       busRdata,
  input logic              rdOwn,
  input logic              wrPermit,
  input logic              wrError,
  input logic              lockedOut
);

  localparam logic [ADDR_W-1:0] StAddr = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] SgAddr = ADDR_W'(STAGE_OFS);

  logic isSt, isSg;
  assign isSt = (busAddr == StAddr);
  assign isSg = (busAddr == SgAddr);

  a_r3_locked_blocks: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |-> !wrPermit);

  a_r3_err_follows: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && lockedOut && !isSt && !isSg) |=> wrError);

  a_r9_err_only_after_reject: assert property (@(posedge clk) disable iff (!rstN)
    wrError |-> $past(busWe && lockedOut && !isSt && !isSg));

  a_r2_arm: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !lockedOut && (isSt || isSg)) |=> lockedOut);

  a_r4_permit_open: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !lockedOut && !isSt && !isSg) |-> wrPermit);

  a_r7_bad_key_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && lockedOut && isSt && busWdata != KEY_UNLOCK) |=> lockedOut);

  a_r6_only_status_opens: assert property (@(posedge clk) disable iff (!rstN)
    (lockedOut && !(busWe && isSt)) |=> lockedOut);

  a_r8_stage_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && isSg) |=> (busRdata == 32'b0 && rdOwn));

  a_r8_idle_read: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> (busRdata == 32'b0 && !rdOwn));

endmodule

bind reg_write_lock wl_lock_checker #(
  .ADDR_W    (ADDR_W),
  .STATUS_OFS(STATUS_OFS),
  .STAGE_OFS (STAGE_OFS),
  .KEY_UNLOCK(KEY_UNLOCK)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busWe    (busWe),
  .busRe    (busRe),
  .busRdata (busRdata),
  .rdOwn    (rdOwn),
  .wrPermit (wrPermit),
  .wrError  (wrError),
  .lockedOut(lockedOut)
);

// File: tb/sim_reg_write_lock.sv
`timescale 1ns/100ps
module sim_reg_write_lock;

  localparam int          AW = 12;
  localparam logic [31:0] KS = 32'hC0DE1248;
  localparam logic [31:0] KU = 32'hC0DEFA73;
  localparam logic [AW-1:0] ST = 12'h000;
  localparam logic [AW-1:0] SG = 12'h07C;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic          busWe = 1'b0;
  logic          busRe = 1'b0;
  logic [31:0]   busRdata;
  logic          rdOwn, wrPermit, wrError, lockedOut;

  int nChecks = 0;
  int nFail   = 0;

  // bench model of the guard
  logic        expLocked = 1'b0;
  logic [31:0] expStage  = '0;

  always #2 clk = ~clk;

  reg_write_lock u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata), .rdOwn(rdOwn),
    .wrPermit(wrPermit), .wrError(wrError), .lockedOut(lockedOut)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit isLock(input logic [AW-1:0] a);
    return (a == ST) || (a == SG);
  endfunction

  function automatic logic [AW-1:0] sweepAddr(input int w);
    if (w < 32) return AW'(w * 4);
    if (w == 32) return 12'h080;
    if (w == 33) return 12'h100;
    if (w == 34) return 12'h800;
    return 12'hFFC;
  endfunction

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    bit expP, expE;
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; busRe = 1'b0;
    #1;
    expP = !expLocked && !isLock(a);
    check(wrPermit == expP, tag, "wrPermit", 32'(wrPermit), 32'(expP));
    @(posedge clk);
    #1;
    busWe = 1'b0;
    expE = expLocked && !isLock(a);
    check(wrError == expE, tag, "wrError", 32'(wrError), 32'(expE));
    if (!expLocked) begin
      if (isLock(a)) begin expLocked = 1'b1; expStage = '0; end
    end else if (a == SG) begin
      expStage = d;
    end else if (a == ST && d == KU && expStage == KS) begin
      expLocked = 1'b0; expStage = '0;
    end
    check(lockedOut == expLocked, tag, "lockedOut", 32'(lockedOut), 32'(expLocked));
  endtask

  task automatic doRead(input logic [AW-1:0] a, input string tag);
    logic [31:0] expD;
    @(negedge clk);
    busAddr = a; busRe = 1'b1; busWe = 1'b0;
    expD = (a == ST) ? {31'b0, expLocked} : 32'b0;
    @(posedge clk);
    #1;
    busRe = 1'b0;
    check(busRdata == expD, tag, "busRdata", busRdata, expD);
    check(rdOwn == isLock(a), tag, "rdOwn", 32'(rdOwn), 32'(isLock(a)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(lockedOut == 1'b0, "R1", "lockedOut at reset", 32'(lockedOut), 32'd0);
    check(wrError == 1'b0, "R1", "wrError at reset", 32'(wrError), 32'd0);
    rstN = 1'b1;
    doRead(ST, "R1");

    // R4 / R8: open guard passes ordinary writes, reads not claimed
    for (int w = 0; w < 36; w++) begin
      if (!isLock(sweepAddr(w))) begin
        doWrite(sweepAddr(w), 32'hA5A5_0000 | 32'(w), "R4");
        doRead(sweepAddr(w), "R8");
      end
    end

    // R2: arm through the status word with zero data
    doWrite(ST, 32'h0, "R2");
    doRead(ST, "R2");
    doRead(SG, "R8");

    // R3 / R9: rejected writes back to back, then a non-rejected one
    for (int w = 0; w < 36; w++) begin
      if (!isLock(sweepAddr(w))) doWrite(sweepAddr(w), 32'(w), "R9");
    end
    doWrite(SG, 32'h0, "R9");
    doWrite(12'h010, 32'h1, "R3");
    doRead(ST, "R3");

    // R7: one-bit misses on both keys
    for (int b = 0; b < 32; b++) begin
      doWrite(SG, KS, "R5");
      doWrite(ST, KU ^ (32'h1 << b), "R7");
    end
    for (int b = 0; b < 32; b++) begin
      doWrite(SG, KS ^ (32'h1 << b), "R5");
      doWrite(ST, KU, "R7");
    end
    doWrite(SG, KU, "R7");
    doWrite(ST, KS, "R7");
    doRead(ST, "R7");

    // R5: last staged word counts, then R6 unlock
    doWrite(SG, 32'h1234_5678, "R5");
    doWrite(SG, KS, "R5");
    doWrite(ST, KU, "R6");
    doRead(ST, "R6");
    doWrite(12'h020, 32'h5, "R4");

    // R6: unlock cleared the staging word
    doWrite(ST, 32'hFFFF_FFFF, "R2");
    doWrite(ST, KU, "R6");
    doRead(ST, "R6");
    doWrite(SG, KS, "R6");
    doWrite(ST, KU, "R6");
    doRead(ST, "R6");

    // R10: arming through staging with the key clears it
    doWrite(SG, KS, "R10");
    doWrite(ST, KU, "R10");
    doRead(ST, "R10");
    doRead(SG, "R8");
    doWrite(SG, KS, "R10");
    doWrite(ST, KU, "R10");
    doRead(ST, "R10");
    doWrite(12'h7F8, 32'h9, "R4");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule